// File: doc/BRIEF.md
# Hit word formatter and sequencer

This block collects hit records from up to eight front-end modules and turns them into one stream of 16-bit words for a serializer link. Each record carries a channel address, a discriminator bit, a 6-bit ADC value, a 6-bit TDC value and an end-of-event flag, and is offered through a valid/ready handshake. A round-robin arbiter picks one module with a pending record. That module is then served until it sends a record marked as the last of its event. The block frames each event with a header word and a trailer word.

A mode input selects the word format. In the plain format each hit takes one word. In the timing format each hit takes two consecutive words: the first holds the address and discriminator, the second holds the TDC and ADC values. The mode is captured when an event starts and is held until that event ends. The output has no backpressure: a word is present whenever `out_valid` is high. `out_sof` marks a header word and `out_eof` marks a trailer word.

The sequencer has five states:
- `ST_IDLE`: waits for any request, then goes to `ST_HEAD`, capturing the module and the mode.
- `ST_HEAD`: emits the header, then goes to `ST_DATA`.
- `ST_DATA`: accepts a record and emits either a plain word or timing word 1. A timing record goes to `ST_DATA2`. A plain record with its last flag set goes to `ST_TRAIL`. Otherwise the state holds.
- `ST_DATA2`: emits timing word 2, then goes to `ST_TRAIL` if the record was the last one, else back to `ST_DATA`.
- `ST_TRAIL`: emits the trailer, then returns to `ST_IDLE`.

Top module: `hit_word_sequencer`

## Requirements
- R1: After reset `out_valid`, `out_sof`, `out_eof` and every `in_ready` bit are 0, and the first event carries event number 0.
- R2: The first word of an event is a header `{4'hE, 1'b0, module[2:0], event_number[7:0]}` with `out_sof`=1 and `out_eof`=0. It is the only word of the event with `out_sof` set.
- R3: In the plain format a hit is one word `{addr[8:0], disc, adc[5:0]}` in bits [15:7], [6] and [5:0].
- R4: In the timing format a hit is two back-to-back words. The first is `{addr[8:0], disc, 6'b0}`. The second is `{4'b0, tdc[5:0], adc[5:0]}`, with the TDC in [11:6] and the ADC in [5:0].
- R5: `in_ready` is at most one-hot. It is set only for the module being served, only while the plain word or timing word 1 is being emitted. It is 0 during timing word 2, the header and the trailer.
- R6: The last word of an event is a trailer `{4'hF, count[11:0]}` with `out_eof`=1, where count is the number of data words in the event: hits in plain mode, twice the hits in timing mode.
- R7: The event number rises by one per event and wraps from 255 to 0.
- R8: Arbitration is round robin. The search for the next module starts one past the module served last and wraps from 7 to 0.
- R9: Once a module is selected, no other module's record is accepted until that module's record with the last flag set has been taken.
- R10: The mode input is sampled only when an event starts. A change during an event has no effect on that event's words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = plain format, 1 = timing format |
| in_valid | input | 8 | Per-module record valid |
| in_ready | output | 8 | Per-module record accepted |
| in_last | input | 8 | Per-module end-of-event flag |
| in_disc | input | 8 | Per-module discriminator bit |
| in_addr | input | 72 | Per-module 9-bit channel address, module m at [m*9 +: 9] |
| in_tdc | input | 48 | Per-module 6-bit TDC, module m at [m*6 +: 6] |
| in_adc | input | 48 | Per-module 6-bit ADC, module m at [m*6 +: 6] |
| out_valid | output | 1 | Output word present |
| out_word | output | 16 | Link word |
| out_sof | output | 1 | Header word marker |
| out_eof | output | 1 | Trailer word marker |

## Verification
The header appears one cycle after the cycle in which a request is seen in `ST_IDLE`. A plain word or timing word 1 appears in the same cycle as the record that produces it, because the data path from the record to the output is combinational. Timing word 2 follows one cycle later, and the trailer comes one cycle after the last data word. Because every output lags its cause by zero or one clock, the bench does not predict cycle numbers. It queues the expected words in their order of emission, and a monitor compares each valid word, its frame markers and the `in_ready` vector mid-cycle, after the inputs driven on the falling edge have settled.

// File: rtl/hws_pkg.sv
package hws_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_DATA,
        ST_DATA2,
        ST_TRAIL
    } seq_state_t;

    localparam logic [3:0] HDR_TAG = 4'hE;
    localparam logic [3:0] TRL_TAG = 4'hF;
    localparam int         WORD_W  = 16;
endpackage

// File: rtl/hws_rr_arb.sv
module hws_rr_arb #(
    parameter int N   = 8,
    parameter int IDW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   req,
    input  logic           advance,
    output logic [IDW-1:0] grant_idx,
    output logic           any_req
);
    logic [IDW-1:0] ptr;

    always_comb begin
        logic found;
        found     = 1'b0;
        grant_idx = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (!found && req[idx]) begin
                found     = 1'b1;
                grant_idx = IDW'(idx);
            end
        end
    end

    assign any_req = |req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (advance && any_req) begin
            ptr <= (int'(grant_idx) == N - 1) ? '0 : grant_idx + IDW'(1);
        end
    end
endmodule

// File: rtl/hws_packer.sv
module hws_packer #(
    parameter int ADDR_W = 9,
    parameter int ADC_W  = 6,
    parameter int TDC_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              disc,
    input  logic [ADC_W-1:0]  adc,
    input  logic [TDC_W-1:0]  tdc,
    output logic [15:0]       plain_w,
    output logic [15:0]       t1_w,
    output logic [15:0]       t2_w
);
    localparam int PAD2 = 16 - TDC_W - ADC_W;

    assign plain_w = {addr, disc, adc};
    assign t1_w    = {addr, disc, {ADC_W{1'b0}}};
    assign t2_w    = {{PAD2{1'b0}}, tdc, adc};
endmodule

// File: rtl/hit_word_sequencer.sv
module hit_word_sequencer
    import hws_pkg::*;
#(
    parameter int N_MOD  = 8,
    parameter int ADDR_W = 9,
    parameter int ADC_W  = 6,
    parameter int TDC_W  = 6,
    parameter int EVT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode,
    input  logic [N_MOD-1:0]        in_valid,
    output logic [N_MOD-1:0]        in_ready,
    input  logic [N_MOD-1:0]        in_last,
    input  logic [N_MOD-1:0]        in_disc,
    input  logic [N_MOD*ADDR_W-1:0] in_addr,
    input  logic [N_MOD*TDC_W-1:0]  in_tdc,
    input  logic [N_MOD*ADC_W-1:0]  in_adc,
    output logic                    out_valid,
    output logic [15:0]             out_word,
    output logic                    out_sof,
    output logic                    out_eof
);
    localparam int ID_W    = (N_MOD > 1) ? $clog2(N_MOD) : 1;
    localparam int CNT_W   = WORD_W - 4;
    localparam int HDR_PAD = WORD_W - 4 - ID_W - EVT_W;

    seq_state_t       state, nxt;
    logic [ID_W-1:0]  sel, grant_idx;
    logic             any_req, advance;
    logic             mode_q, last_q;
    logic [CNT_W-1:0] cnt;
    logic [EVT_W-1:0] evt;
    logic [15:0]      t2_q;

    logic              cur_valid, cur_last, cur_disc;
    logic [ADDR_W-1:0] cur_addr;
    logic [TDC_W-1:0]  cur_tdc;
    logic [ADC_W-1:0]  cur_adc;
    logic [15:0]       plain_w, t1_w, t2_w;

    assign cur_valid = in_valid[sel];
    assign cur_last  = in_last[sel];
    assign cur_disc  = in_disc[sel];
    assign cur_addr  = in_addr[sel*ADDR_W +: ADDR_W];
    assign cur_tdc   = in_tdc[sel*TDC_W +: TDC_W];
    assign cur_adc   = in_adc[sel*ADC_W +: ADC_W];

    hws_rr_arb #(.N(N_MOD), .IDW(ID_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (in_valid),
        .advance   (advance),
        .grant_idx (grant_idx),
        .any_req   (any_req)
    );

    hws_packer #(.ADDR_W(ADDR_W), .ADC_W(ADC_W), .TDC_W(TDC_W)) u_pack (
        .addr    (cur_addr),
        .disc    (cur_disc),
        .adc     (cur_adc),
        .tdc     (cur_tdc),
        .plain_w (plain_w),
        .t1_w    (t1_w),
        .t2_w    (t2_w)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt     = state;
        advance = 1'b0;
        unique case (state)
            ST_IDLE: begin
                advance = 1'b1;
                if (any_req) nxt = ST_HEAD;
            end
            ST_HEAD:  nxt = ST_DATA;
            ST_DATA: begin
                if (cur_valid) begin
                    if (mode_q)        nxt = ST_DATA2;
                    else if (cur_last) nxt = ST_TRAIL;
                end
            end
            ST_DATA2: nxt = last_q ? ST_TRAIL : ST_DATA;
            ST_TRAIL: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // event context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel    <= '0;
            mode_q <= 1'b0;
            last_q <= 1'b0;
            cnt    <= '0;
            evt    <= '0;
            t2_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (any_req) begin
                        sel    <= grant_idx;
                        mode_q <= mode;
                        cnt    <= '0;
                    end
                end
                ST_DATA: begin
                    if (cur_valid) begin
                        cnt    <= cnt + CNT_W'(1);
                        t2_q   <= t2_w;
                        last_q <= cur_last;
                    end
                end
                ST_DATA2: cnt <= cnt + CNT_W'(1);
                ST_TRAIL: evt <= evt + EVT_W'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready  = '0;
        out_valid = 1'b0;
        out_sof   = 1'b0;
        out_eof   = 1'b0;
        out_word  = '0;
        unique case (state)
            ST_IDLE: ;
            ST_HEAD: begin
                out_valid = 1'b1;
                out_sof   = 1'b1;
                out_word  = {HDR_TAG, {HDR_PAD{1'b0}}, sel, evt};
            end
            ST_DATA: begin
                in_ready[sel] = 1'b1;
                out_valid     = cur_valid;
                out_word      = mode_q ? t1_w : plain_w;
            end
            ST_DATA2: begin
                out_valid = 1'b1;
                out_word  = t2_q;
            end
            ST_TRAIL: begin
                out_valid = 1'b1;
                out_eof   = 1'b1;
                out_word  = {TRL_TAG, cnt};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hws_checker.sv
module hws_checker
    import hws_pkg::*;
#(
    parameter int N_MOD = 8,
    parameter int EVT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_MOD-1:0] in_ready,
    input logic             out_valid,
    input logic             out_sof,
    input logic             out_eof,
    input logic [15:0]      out_word,
    input seq_state_t       state,
    input logic             mode_q,
    input logic [EVT_W-1:0] evt
);
    AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready)); // R5
    AST_NO_READY_WORD2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA2) |-> (in_ready == '0)); // R5
    AST_HDR_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_valid && !out_eof && out_word[15:12] == TRL_TAG - 4'd1)); // R2
    AST_TRL_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eof) |=> !out_valid); // R6
    AST_EVT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eof) |=> (evt == $past(evt) + EVT_W'(1))); // R7
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(mode_q)); // R10
endmodule

bind hit_word_sequencer hws_checker #(.N_MOD(N_MOD), .EVT_W(EVT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_eof   (out_eof),
    .out_word  (out_word),
    .state     (state),
    .mode_q    (mode_q),
    .evt       (evt)
);

// File: tb/hit_word_sequencer_bench.sv
module hit_word_sequencer_bench;
    localparam int N = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mode = 1'b0;
    logic [N-1:0]    in_valid = '0, in_last = '0, in_disc = '0;
    logic [N-1:0]    in_ready;
    logic [N*9-1:0]  in_addr = '0;
    logic [N*6-1:0]  in_tdc = '0, in_adc = '0;
    logic            out_valid, out_sof, out_eof;
    logic [15:0]     out_word;

    int tests = 0, fails = 0;
    int exp_evt = 0;

    // record: {last, addr[8:0], disc, tdc[5:0], adc[5:0]}
    logic [22:0] hq [N][$];
    logic [N-1:0] take = '0;
    // expected item: {kind[1:0], ready[7:0], sof, eof, word[15:0]}
    logic [27:0] expq [$];

    always #4 clk = ~clk;

    hit_word_sequencer u_hit_word_sequencer (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
        .in_disc(in_disc), .in_addr(in_addr), .in_tdc(in_tdc), .in_adc(in_adc),
        .out_valid(out_valid), .out_word(out_word),
        .out_sof(out_sof), .out_eof(out_eof)
    );

    function automatic string kind_name(input logic [1:0] k);
        case (k)
            2'd0:    return "R2/R7/R8 header";
            2'd1:    return "R3/R4/R5/R9/R10 data word";
            2'd2:    return "R4/R5 timing word 2";
            default: return "R6 trailer";
        endcase
    endfunction

    task automatic push_exp(input logic [1:0] k, input logic [7:0] rdy,
                            input logic sof, input logic eof, input logic [15:0] w);
        expq.push_back({k, rdy, sof, eof, w});
    endtask

    task automatic add_event(input int m, input int nh, input logic md, input int seed);
        logic [11:0] cnt;
        cnt = 0;
        push_exp(2'd0, 8'h00, 1'b1, 1'b0, {4'hE, 1'b0, 3'(m), 8'(exp_evt)});
        for (int i = 0; i < nh; i++) begin
            logic [8:0] a; logic d; logic [5:0] t, c; logic l;
            a = 9'((seed * 37 + i * 11) % 512);
            d = 1'((i + seed) % 2);
            t = 6'((seed + i * 5) % 64);
            c = 6'((seed * 3 + i * 7 + 1) % 64);
            l = (i == nh - 1);
            hq[m].push_back({l, a, d, t, c});
            if (md) begin
                push_exp(2'd1, 8'(1 << m), 1'b0, 1'b0, {a, d, 6'b0});
                push_exp(2'd2, 8'h00, 1'b0, 1'b0, {4'b0, t, c});
                cnt = cnt + 12'd2;
            end else begin
                push_exp(2'd1, 8'(1 << m), 1'b0, 1'b0, {a, d, c});
                cnt = cnt + 12'd1;
            end
        end
        push_exp(2'd3, 8'h00, 1'b0, 1'b1, {4'hF, cnt});
        exp_evt = (exp_evt + 1) % 256;
    endtask

    // driver: retire accepted records, present the next ones
    always @(negedge clk) begin
        for (int m = 0; m < N; m++) begin
            if (take[m]) void'(hq[m].pop_front());
            if (hq[m].size() > 0) begin
                in_valid[m]        = 1'b1;
                in_last[m]         = hq[m][0][22];
                in_addr[m*9 +: 9]  = hq[m][0][21:13];
                in_disc[m]         = hq[m][0][12];
                in_tdc[m*6 +: 6]   = hq[m][0][11:6];
                in_adc[m*6 +: 6]   = hq[m][0][5:0];
            end else begin
                in_valid[m] = 1'b0;
            end
        end
        #1;
        take = in_valid & in_ready;
    end

    // monitor: compare each emitted word with the scoreboard
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid) begin
            tests++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R9 unexpected word act=%h exp=none", out_word);
            end else begin
                logic [27:0] e;
                e = expq.pop_front();
                if ({in_ready, out_sof, out_eof, out_word} != e[25:0]) begin
                    fails++;
                    $display("FAIL %s act rdy=%h sof=%b eof=%b word=%h exp rdy=%h sof=%b eof=%b word=%h",
                             kind_name(e[27:26]), in_ready, out_sof, out_eof, out_word,
                             e[25:18], e[17], e[16], e[15:0]);
                end
            end
        end
    end

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #3;
        tests++;
        if (out_valid || out_sof || out_eof || in_ready != '0) begin
            fails++;
            $display("FAIL R1 reset outputs act=%b%b%b rdy=%h exp=000 rdy=00",
                     out_valid, out_sof, out_eof, in_ready);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R3: first event plain, event number 0
        mode = 1'b0;
        add_event(0, 5, 1'b0, 3);
        drain();
        // R4 R5: timing format
        mode = 1'b1;
        add_event(3, 4, 1'b1, 9);
        drain();
        // R8 R9: simultaneous events on 1,5,6 with search starting at 4
        mode = 1'b0;
        add_event(5, 3, 1'b0, 20);
        add_event(6, 2, 1'b0, 21);
        add_event(1, 4, 1'b0, 22);
        drain();
        // R8: wrap from 7 to 0, search starting at 2
        add_event(7, 2, 1'b0, 30);
        add_event(1, 1, 1'b0, 31);
        drain();
        // R10: mode change mid-event has no effect on that event
        add_event(2, 8, 1'b0, 40);
        repeat (4) @(negedge clk);
        mode = 1'b1;
        drain();
        // R10: the next event takes the new mode; single-hit timing event, R6 count 2
        add_event(4, 1, 1'b1, 41);
        drain();
        // R7: event number wrap
        mode = 1'b0;
        for (int i = 0; i < 250; i++) begin
            add_event(i % N, 1, 1'b0, 50 + i);
            drain();
        end
        tests++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL R6 words missing act=%0d exp=0", expq.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R9 watchdog expired act=running exp=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule